// File: doc/BRIEF.md
# Bridge Error Classifier and Reporter

This block sits beside the error paths of a bridge between a host-side packet link and a secondary PCI bus. It receives one-cycle error strobes from the rest of the bridge and turns them into sticky log bits, into fatal and non-fatal interrupt requests, and into the completion code that the PCI target engine must give the waiting PCI master. Four kinds of event are classified: a response that matches no outstanding request, an upstream error response (with or without a flag marking a non-existent address), the secondary bus system-error line, and a configuration-register access that crosses a 32-bit aligned block.

Configuration enables decide whether each logged source raises a fatal interrupt, a non-fatal interrupt, or nothing. A master-abort mode bit decides whether a non-existent-address error becomes a target abort or a normal completion with all-ones data. Software clears the log by writing ones to the bits it wants to clear. Register decode and the bus protocol engines live outside this block.

Top module: `bridge_err_report`

## Requirements
- R1: A strobe on `rsp_mismatch_i` sets log bit 0. While that bit is set, `fatal_irq_o` is high if `cfg_mm_fatal_en_i` is set and `nonfatal_irq_o` is high if `cfg_mm_nonfatal_en_i` is set. The event leaves `pci_rsp_o` at 2'b00 (no action).
- R2: An upstream error strobe on any channel with its non-existent-address flag clear sets log bit 1 (received target abort). On the next clock edge `pci_rsp_o` becomes 2'b10 (target abort) for one cycle.
- R3: An upstream error strobe with its non-existent-address flag set sets log bit 2 (received master abort). On the next edge `pci_rsp_o` becomes 2'b10 if `cfg_mabort_mode_i` is 1. It becomes 2'b01 (normal completion, all-ones data) if that mode bit is 0.
- R4: The active-low `serr_n_i` is synchronised, and its falling edge sets log bit 3 (detected SERR) within five clocks. While bit 3 is set, `fatal_irq_o` is high when `cfg_serr_en_i` and `cfg_serr_fatal_en_i` are both set, and `nonfatal_irq_o` is high when `cfg_serr_en_i` is set and `cfg_serr_fatal_en_i` is clear.
- R5: If `serr_n_i` stays low, log bit 3 is set only once: after it is cleared it stays clear until the line is released and asserted again.
- R6: A strobe on `csr_misalign_i` makes `csr_err_rsp_o` pulse for one cycle on the next edge. It changes no log bit, no interrupt and no `pci_rsp_o` value.
- R7: The interrupt outputs are the OR of all logged sources that are enabled. They drop as soon as the log bits behind them are cleared.
- R8: With `clr_valid_i` high, each log bit whose `clr_mask_i` bit is 1 is cleared at the edge. A bit that is set by an event in the same cycle stays set.
- R9: If events arrive in the same cycle, every matching log bit is set. `pci_rsp_o` then gives target abort (2'b10) priority over all-ones completion (2'b01).
- R10: After reset the log is 0, both interrupts are low, `pci_rsp_o` is 2'b00 and `csr_err_rsp_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_mismatch_i | input | 1 | Response matched no outstanding request (strobe) |
| up_err_i | input | NUM_CH | Upstream error response per channel (strobe) |
| up_nxa_i | input | NUM_CH | Non-existent-address flag qualifying `up_err_i` |
| serr_n_i | input | 1 | Secondary bus system error, active low, asynchronous |
| csr_misalign_i | input | 1 | Configuration access spans two 32-bit blocks (strobe) |
| cfg_mm_fatal_en_i | input | 1 | Mismatch raises fatal interrupt |
| cfg_mm_nonfatal_en_i | input | 1 | Mismatch raises non-fatal interrupt |
| cfg_mabort_mode_i | input | 1 | 1: non-existent address gives target abort; 0: all-ones completion |
| cfg_serr_en_i | input | 1 | System-error reporting enable |
| cfg_serr_fatal_en_i | input | 1 | System error reported as fatal when set, non-fatal when clear |
| clr_valid_i | input | 1 | Write-one-to-clear strobe for the log |
| clr_mask_i | input | 4 | Log bits to clear |
| log_o | output | 4 | Log: bit0 mismatch, bit1 rcvd target abort, bit2 rcvd master abort, bit3 detected SERR |
| fatal_irq_o | output | 1 | Fatal interrupt request |
| nonfatal_irq_o | output | 1 | Non-fatal interrupt request |
| pci_rsp_o | output | 2 | PCI completion code: 00 none, 01 all-ones, 10 target abort |
| csr_err_rsp_o | output | 1 | Error response for a misaligned configuration access |

## Verification
On every cycle the assertions check four things: a log bit set by an event is present on the following cycle, a write-one-to-clear with no competing event empties the masked bits, any target-abort-class strobe yields code 2'b10 on the next edge, and the edge detector never reports two rises back to back. Only the directed scenarios can show the full mapping from enable combinations to fatal or non-fatal interrupts, the mode-dependent choice of completion code, and the once-only logging of a held system-error line. The same holds for the absence of side effects from a misaligned configuration access.

// File: rtl/berr_pkg.sv
package berr_pkg;
   localparam int LOG_W       = 4;
   localparam int LB_MISMATCH = 0;
   localparam int LB_RCVD_TA  = 1;
   localparam int LB_RCVD_MA  = 2;
   localparam int LB_DET_SERR = 3;

   typedef enum logic [1:0] {
      RSP_NONE   = 2'b00,
      RSP_ALL1   = 2'b01,
      RSP_TABORT = 2'b10
   } pci_rsp_e;
endpackage

// File: rtl/berr_serr_sync.sv
module berr_serr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic serr_n_i,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("berr_serr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], ~serr_n_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~last_q;

   // R5
   single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/berr_rsp_merge.sv
module berr_rsp_merge
   import berr_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] err_i,
   input  logic [NUM_CH-1:0] nxa_i,
   input  logic              mabort_mode_i,
   output logic              set_ta_o,
   output logic              set_ma_o,
   output pci_rsp_e          rsp_o
);
   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("berr_rsp_merge: NUM_CH must be at least 1");
      end
   endgenerate

   logic [NUM_CH-1:0] ta_ch;
   logic [NUM_CH-1:0] a1_ch;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
         assign ta_ch[gi] = err_i[gi] & (~nxa_i[gi] | mabort_mode_i);
         assign a1_ch[gi] = err_i[gi] & nxa_i[gi] & ~mabort_mode_i;
      end
   endgenerate

   assign set_ta_o = |(err_i & ~nxa_i);
   assign set_ma_o = |(err_i & nxa_i);

   pci_rsp_e rsp_d, rsp_q;

   always_comb begin
      if (|ta_ch)      rsp_d = RSP_TABORT;
      else if (|a1_ch) rsp_d = RSP_ALL1;
      else             rsp_d = RSP_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rsp_q <= RSP_NONE;
      else        rsp_q <= rsp_d;
   end

   assign rsp_o = rsp_q;

   // R9
   tabort_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(err_i & ~nxa_i)) |=> (rsp_o == RSP_TABORT));
endmodule

// File: rtl/berr_log_w1c.sv
module berr_log_w1c #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_valid_i,
   input  logic [W-1:0] clr_mask_i,
   output logic [W-1:0] log_o
);
   logic [W-1:0] log_q;
   logic [W-1:0] clr_eff;

   assign clr_eff = clr_valid_i ? clr_mask_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) log_q <= '0;
      else        log_q <= (log_q & ~clr_eff) | set_i;
   end

   assign log_o = log_q;

   // R8
   set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((log_o & $past(set_i)) == $past(set_i)));

   // R8
   clr_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_valid_i && (set_i == '0)) |=> ((log_o & $past(clr_mask_i)) == '0));
endmodule

// File: rtl/berr_irq_map.sv
module berr_irq_map
   import berr_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LOG_W-1:0] log_i,
   input  logic             mm_fatal_en_i,
   input  logic             mm_nonfatal_en_i,
   input  logic             serr_en_i,
   input  logic             serr_fatal_en_i,
   output logic             fatal_o,
   output logic             nonfatal_o
);
   logic fatal_d, nonfatal_d;

   always_comb begin
      fatal_d    = (log_i[LB_MISMATCH] & mm_fatal_en_i)
                 | (log_i[LB_DET_SERR] & serr_en_i & serr_fatal_en_i);
      nonfatal_d = (log_i[LB_MISMATCH] & mm_nonfatal_en_i)
                 | (log_i[LB_DET_SERR] & serr_en_i & ~serr_fatal_en_i);
   end

   generate
      if (IRQ_REG) begin : g_reg
         logic fatal_q, nonfatal_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               fatal_q    <= 1'b0;
               nonfatal_q <= 1'b0;
            end else begin
               fatal_q    <= fatal_d;
               nonfatal_q <= nonfatal_d;
            end
         end
         assign fatal_o    = fatal_q;
         assign nonfatal_o = nonfatal_q;
      end else begin : g_comb
         assign fatal_o    = fatal_d;
         assign nonfatal_o = nonfatal_d;

         // R7
         no_src_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (log_i == '0) |-> (!fatal_o && !nonfatal_o));
      end
   endgenerate
endmodule

// File: rtl/bridge_err_report.sv
module bridge_err_report
   import berr_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rsp_mismatch_i,
   input  logic [NUM_CH-1:0] up_err_i,
   input  logic [NUM_CH-1:0] up_nxa_i,
   input  logic              serr_n_i,
   input  logic              csr_misalign_i,
   input  logic              cfg_mm_fatal_en_i,
   input  logic              cfg_mm_nonfatal_en_i,
   input  logic              cfg_mabort_mode_i,
   input  logic              cfg_serr_en_i,
   input  logic              cfg_serr_fatal_en_i,
   input  logic              clr_valid_i,
   input  logic [3:0]        clr_mask_i,
   output logic [3:0]        log_o,
   output logic              fatal_irq_o,
   output logic              nonfatal_irq_o,
   output logic [1:0]        pci_rsp_o,
   output logic              csr_err_rsp_o
);
   logic       serr_rise;
   logic       set_ta, set_ma;
   pci_rsp_e   rsp;
   logic [LOG_W-1:0] set_vec;
   logic [LOG_W-1:0] log_q;
   logic       misalign_q;

   berr_serr_sync #(.STAGES(SYNC_STAGES)) u_serr (
      .clk(clk), .rst_n(rst_n), .serr_n_i(serr_n_i), .rise_o(serr_rise)
   );

   berr_rsp_merge #(.NUM_CH(NUM_CH)) u_merge (
      .clk(clk), .rst_n(rst_n), .err_i(up_err_i), .nxa_i(up_nxa_i),
      .mabort_mode_i(cfg_mabort_mode_i), .set_ta_o(set_ta), .set_ma_o(set_ma),
      .rsp_o(rsp)
   );

   always_comb begin
      set_vec              = '0;
      set_vec[LB_MISMATCH] = rsp_mismatch_i;
      set_vec[LB_RCVD_TA]  = set_ta;
      set_vec[LB_RCVD_MA]  = set_ma;
      set_vec[LB_DET_SERR] = serr_rise;
   end

   berr_log_w1c #(.W(LOG_W)) u_log (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_valid_i(clr_valid_i),
      .clr_mask_i(clr_mask_i), .log_o(log_q)
   );

   berr_irq_map #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .log_i(log_q),
      .mm_fatal_en_i(cfg_mm_fatal_en_i), .mm_nonfatal_en_i(cfg_mm_nonfatal_en_i),
      .serr_en_i(cfg_serr_en_i), .serr_fatal_en_i(cfg_serr_fatal_en_i),
      .fatal_o(fatal_irq_o), .nonfatal_o(nonfatal_irq_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) misalign_q <= 1'b0;
      else        misalign_q <= csr_misalign_i;
   end

   assign log_o         = log_q;
   assign pci_rsp_o     = rsp;
   assign csr_err_rsp_o = misalign_q;

   // R6
   misalign_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      csr_misalign_i |=> csr_err_rsp_o);

   // R1
   mismatch_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_mismatch_i |=> log_o[LB_MISMATCH]);
endmodule

// File: tb/bridge_err_report_tb.sv
module bridge_err_report_tb;
   logic clk = 1'b0;
   logic rst_n;
   logic rsp_mismatch_i;
   logic [1:0] up_err_i, up_nxa_i;
   logic serr_n_i, csr_misalign_i;
   logic cfg_mm_fatal_en_i, cfg_mm_nonfatal_en_i, cfg_mabort_mode_i;
   logic cfg_serr_en_i, cfg_serr_fatal_en_i;
   logic clr_valid_i;
   logic [3:0] clr_mask_i;
   logic [3:0] log_o;
   logic fatal_irq_o, nonfatal_irq_o, csr_err_rsp_o;
   logic [1:0] pci_rsp_o;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   bridge_err_report u_dut (
      .clk(clk), .rst_n(rst_n), .rsp_mismatch_i(rsp_mismatch_i),
      .up_err_i(up_err_i), .up_nxa_i(up_nxa_i), .serr_n_i(serr_n_i),
      .csr_misalign_i(csr_misalign_i), .cfg_mm_fatal_en_i(cfg_mm_fatal_en_i),
      .cfg_mm_nonfatal_en_i(cfg_mm_nonfatal_en_i),
      .cfg_mabort_mode_i(cfg_mabort_mode_i), .cfg_serr_en_i(cfg_serr_en_i),
      .cfg_serr_fatal_en_i(cfg_serr_fatal_en_i), .clr_valid_i(clr_valid_i),
      .clr_mask_i(clr_mask_i), .log_o(log_o), .fatal_irq_o(fatal_irq_o),
      .nonfatal_irq_o(nonfatal_irq_o), .pci_rsp_o(pci_rsp_o),
      .csr_err_rsp_o(csr_err_rsp_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic idle_inputs();
      rsp_mismatch_i = 0; up_err_i = 0; up_nxa_i = 0; csr_misalign_i = 0;
      clr_valid_i = 0; clr_mask_i = 0;
   endtask

   task automatic clear_all();
      @(negedge clk); clr_valid_i = 1; clr_mask_i = 4'hF;
      step();
      @(negedge clk); clr_valid_i = 0; clr_mask_i = 0;
   endtask

   task automatic cfg(input logic mf, input logic mn, input logic mm,
                      input logic se, input logic sf);
      cfg_mm_fatal_en_i = mf; cfg_mm_nonfatal_en_i = mn; cfg_mabort_mode_i = mm;
      cfg_serr_en_i = se; cfg_serr_fatal_en_i = sf;
   endtask

   task automatic t_reset();
      chk("R10 log", log_o, 0);
      chk("R10 fatal", fatal_irq_o, 0);
      chk("R10 nonfatal", nonfatal_irq_o, 0);
      chk("R10 rsp", pci_rsp_o, 0);
      chk("R10 csr_err", csr_err_rsp_o, 0);
   endtask

   task automatic t_mismatch(input logic mf, input logic mn);
      cfg(mf, mn, 0, 0, 0);
      @(negedge clk); rsp_mismatch_i = 1;
      step();
      chk("R1 log", log_o, 4'b0001);
      chk("R1 fatal", fatal_irq_o, mf);
      chk("R1 nonfatal", nonfatal_irq_o, mn);
      chk("R1 no pci action", pci_rsp_o, 2'b00);
      @(negedge clk); rsp_mismatch_i = 0;
      clear_all();
      #1;
      chk("R7 irq drops after clear", {fatal_irq_o, nonfatal_irq_o}, 0);
   endtask

   task automatic t_uperr(input logic nxa, input logic mode, input logic [1:0] exp_rsp,
                          input logic [3:0] exp_log, input string tag);
      cfg(0, 0, mode, 0, 0);
      @(negedge clk); up_err_i = 2'b01; up_nxa_i = {1'b0, nxa};
      step();
      chk({tag, " log"}, log_o, exp_log);
      chk({tag, " rsp"}, pci_rsp_o, exp_rsp);
      @(negedge clk); up_err_i = 0; up_nxa_i = 0;
      step();
      chk({tag, " rsp one cycle"}, pci_rsp_o, 2'b00);
      clear_all();
   endtask

   task automatic t_serr(input logic se, input logic sf);
      cfg(0, 0, 0, se, sf);
      @(negedge clk); serr_n_i = 0;
      repeat (5) step();
      chk("R4 serr log", log_o, 4'b1000);
      chk("R4 serr fatal", fatal_irq_o, se & sf);
      chk("R4 serr nonfatal", nonfatal_irq_o, se & ~sf);
      clear_all();
      repeat (4) step();
      chk("R5 held serr logs once", log_o, 4'b0000);
      @(negedge clk); serr_n_i = 1;
      repeat (4) step();
      clear_all();
   endtask

   task automatic t_misalign();
      cfg(1, 1, 0, 1, 1);
      @(negedge clk); csr_misalign_i = 1;
      step();
      chk("R6 err rsp pulse", csr_err_rsp_o, 1);
      chk("R6 no log", log_o, 0);
      chk("R6 no pci rsp", pci_rsp_o, 0);
      chk("R6 no irq", {fatal_irq_o, nonfatal_irq_o}, 0);
      @(negedge clk); csr_misalign_i = 0;
      step();
      chk("R6 pulse ends", csr_err_rsp_o, 0);
   endtask

   task automatic t_same_cycle();
      cfg(0, 1, 0, 0, 0);
      @(negedge clk); up_err_i = 2'b11; up_nxa_i = 2'b01; rsp_mismatch_i = 1;
      step();
      chk("R9 all logs", log_o, 4'b0111);
      chk("R9 target abort wins", pci_rsp_o, 2'b10);
      chk("R7 nonfatal from mismatch", nonfatal_irq_o, 1);
      @(negedge clk); idle_inputs();
      clear_all();
   endtask

   task automatic t_clear_vs_set();
      cfg(0, 0, 0, 0, 0);
      @(negedge clk); up_err_i = 2'b01; up_nxa_i = 2'b01;
      step();
      @(negedge clk); up_err_i = 2'b10; up_nxa_i = 2'b00;
      clr_valid_i = 1; clr_mask_i = 4'b0110;
      step();
      chk("R8 set beats clear, masked bit cleared", log_o, 4'b0010);
      @(negedge clk); idle_inputs();
      @(negedge clk); clr_valid_i = 1; clr_mask_i = 4'b0001;
      step();
      chk("R8 unmasked bit kept", log_o, 4'b0010);
      @(negedge clk); idle_inputs();
      clear_all();
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      rst_n = 0; serr_n_i = 1;
      idle_inputs();
      cfg(0, 0, 0, 0, 0);
      repeat (3) step();
      @(negedge clk); rst_n = 1;
      step();
      t_reset();
      t_mismatch(1, 0);
      t_mismatch(0, 1);
      t_mismatch(0, 0);
      t_uperr(0, 0, 2'b10, 4'b0010, "R2");
      t_uperr(1, 1, 2'b10, 4'b0100, "R3 mode1");
      t_uperr(1, 0, 2'b01, 4'b0100, "R3 mode0");
      t_serr(1, 1);
      t_serr(1, 0);
      t_serr(0, 1);
      t_misalign();
      t_same_cycle();
      t_clear_vs_set();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule